// File: doc/BRIEF.md
# External Bus Strobe Generator

This block sits between an internal bus master and an external memory bus with a 24-bit address. It accepts one access request at a time: an address, a byte or 16-bit word size, and a read/write direction. It then runs one or two external bus cycles. Each cycle opens with a one-clock address-latch pulse and continues with a strobe phase. The strobe phase lasts one clock plus a per-region wait count, and it is stretched further for as long as the ready input is low. When the last cycle finishes the block raises a one-clock completion pulse.

The external data path is either 16 or 8 bits wide, chosen by a static width pin. Writes use one of two strobe schemes, chosen by a mode bit. In the split scheme there is one write strobe per byte lane. In the single scheme there is one write strobe, and a separate high-byte enable marks cycles that touch the odd byte. An external master can take the bus with a hold request. Hold is granted only while no access is in progress, and it is acknowledged on a dedicated active-low output. The top address bit is driven out inverted.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rst` is high and in the clock after it, `rd_n`, `wr_lo_n`, `wr_hi_n` and `hold_ack_n` are high and `addr_latch` and `acc_done` are low.
- R2: Every external cycle starts with exactly one clock of `addr_latch` high, with all strobes high. The strobe phase follows in the very next clock. During the latch clock `ext_addr` shows the cycle's byte address with bit 23 inverted.
- R3: In a read cycle `rd_n` is low for the whole strobe phase in both modes. `rd_n` and `wr_lo_n` are never low together.
- R4: With `split_strobes`=1, a write drives `wr_lo_n` low when the cycle writes the even byte: address bit 0 = 0, a word cycle, or any cycle on the 8-bit bus. It drives `wr_hi_n` low when the cycle writes the odd byte on the 16-bit bus: address bit 0 = 1, or a word cycle. Both stay high on reads.
- R5: With `split_strobes`=0, `wr_lo_n` is the write strobe and goes low in every write cycle. `wr_hi_n` is a high-byte enable that goes low in any cycle, read or write, whose address bit 0 = 1 or which is a word cycle.
- R6: `narrow_bus`=0 selects the 16-bit bus and `narrow_bus`=1 the 8-bit bus. A word access (`acc_word`=1) runs as one word cycle on the 16-bit bus at an even address. Otherwise it runs as two byte cycles, at the address and then at the address plus one, modulo 2^24.
- R7: Wait counts: region r = cycle address bits [23:22] uses `wait_cfg[2r+1:2r]` = W. With `rdy_n` high the strobe phase lasts W+1 clocks. The region is taken from each byte cycle's own address.
- R8: The strobe phase ends only at a clock edge where the wait count is used up and `rdy_n` is sampled high. While `rdy_n` is low the phase is stretched.
- R9: `acc_done` is high for exactly one clock, the clock after the final strobe phase, with all strobes high. A request first sampled in an idle clock shows `addr_latch` in the next clock.
- R10: When `hold_n` is sampled low in an idle clock, `hold_ack_n` goes low in the next clock. Hold takes precedence over a request sampled in the same clock. While held there is no `addr_latch` pulse and no strobe.
- R11: A hold request that arrives during an access is not granted until the access has completed and `acc_done` has been shown.
- R12: While held, the first edge that samples `hold_n` high returns `hold_ack_n` high. A pending request then shows `addr_latch` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held with its operands until `acc_done` |
| addr | input | 24 | Byte address of the access |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_write | input | 1 | 1 = write, 0 = read |
| narrow_bus | input | 1 | Data width pin: 0 = 16-bit bus, 1 = 8-bit bus |
| split_strobes | input | 1 | 1 = per-lane write strobes, 0 = write strobe plus high-byte enable |
| wait_cfg | input | 8 | Two-bit wait count for each of four address regions |
| rdy_n | input | 1 | Active-low ready; low stretches the strobe phase |
| hold_n | input | 1 | Active-low bus hold request |
| ext_addr | output | 24 | External address, bit 23 inverted |
| rd_n | output | 1 | Read strobe, active low |
| wr_lo_n | output | 1 | Low-lane write strobe, or the only write strobe |
| wr_hi_n | output | 1 | High-lane write strobe, or high-byte enable |
| addr_latch | output | 1 | Address latch enable pulse |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| acc_done | output | 1 | One-clock completion pulse |

## Verification
The main sweep covers both strobe modes and both bus widths. It crosses these with both access sizes, both directions, even and odd addresses, all four regions and two wait maps. The strobe pattern separates the two modes and the lane decode. The count of latch pulses separates single-cycle from split accesses. The strobe length exposes a wrong region or wait field. Extra cases cover an address split across a region boundary, and one split across the top of the address space where it wraps. Other cases hold ready low past and short of the wait count, raise hold together with a request, and raise hold in the middle of an access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_STRB = 3'd2,
    ST_END  = 3'd3,
    ST_HOLD = 3'd4
  } xb_state_e;
endpackage

// File: rtl/xbus_wait_sel.sv
module xbus_wait_sel #(
  parameter int NREG = 4,
  parameter int WW   = 2,
  localparam int RB  = $clog2(NREG)
) (
  input  logic [RB-1:0]      region,
  input  logic [NREG*WW-1:0] cfg,
  output logic [WW-1:0]      waits
);
  logic [WW-1:0] fld [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_fld
    assign fld[g] = cfg[g*WW +: WW];
  end

  assign waits = fld[region];
endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
  import xbus_pkg::*;
(
  input  xb_state_e st,
  input  logic      is_wr,
  input  logic      split,
  input  logic      narrow,
  input  logic      word,
  input  logic      odd,
  output logic      rd_n,
  output logic      lo_n,
  output logic      hi_n,
  output logic      ale
);
  logic active;

  always_comb begin
    active = (st == ST_STRB);
    ale    = (st == ST_ADDR);
    rd_n   = !(active && !is_wr);
    if (split) begin
      lo_n = !(active && is_wr && (narrow || word || !odd));
      hi_n = !(active && is_wr && !narrow && (word || odd));
    end else begin
      lo_n = !(active && is_wr);
      hi_n = !(active && (word || odd));
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW   = 24,
  parameter int NREG = 4,
  parameter int WW   = 2,
  localparam int RB  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [AW-1:0]     addr,
  input  logic              acc_word,
  input  logic              acc_write,
  input  logic              narrow_bus,
  input  logic              split_strobes,
  input  logic [NREG*WW-1:0] wait_cfg,
  input  logic              rdy_n,
  input  logic              hold_n,
  output xb_state_e         st_nx,
  output logic [AW-1:0]     addr_nx,
  output logic              word_nx,
  output logic              wr_nx,
  output logic              split_nx,
  output logic              narrow_nx
);
  xb_state_e     st_q;
  logic [AW-1:0] cyc_q;
  logic          word_q, more_q, wr_q, split_q, nar_q;
  logic [WW-1:0] cnt_q, cnt_n, waits;
  logic          more_n, brk;

  xbus_wait_sel #(.NREG(NREG), .WW(WW)) u_wait (
    .region (cyc_q[AW-1 -: RB]),
    .cfg    (wait_cfg),
    .waits  (waits)
  );

  always_comb begin
    st_nx     = st_q;
    addr_nx   = cyc_q;
    word_nx   = word_q;
    more_n    = more_q;
    cnt_n     = cnt_q;
    wr_nx     = wr_q;
    split_nx  = split_q;
    narrow_nx = nar_q;
    brk       = acc_word && (narrow_bus || addr[0]);
    case (st_q)
      ST_IDLE: begin
        if (!hold_n) begin
          st_nx = ST_HOLD;
        end else if (req) begin
          st_nx     = ST_ADDR;
          addr_nx   = addr;
          word_nx   = acc_word && !brk;
          more_n    = brk;
          wr_nx     = acc_write;
          split_nx  = split_strobes;
          narrow_nx = narrow_bus;
        end
      end
      ST_ADDR: begin
        st_nx = ST_STRB;
        cnt_n = waits;
      end
      ST_STRB: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (rdy_n) begin
          if (more_q) begin
            st_nx   = ST_ADDR;
            addr_nx = cyc_q + AW'(1);
            more_n  = 1'b0;
            word_nx = 1'b0;
          end else begin
            st_nx = ST_END;
          end
        end
      end
      ST_END:  st_nx = ST_IDLE;
      ST_HOLD: if (hold_n) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cyc_q   <= '0;
      word_q  <= 1'b0;
      more_q  <= 1'b0;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      split_q <= 1'b0;
      nar_q   <= 1'b0;
    end else begin
      st_q    <= st_nx;
      cyc_q   <= addr_nx;
      word_q  <= word_nx;
      more_q  <= more_n;
      cnt_q   <= cnt_n;
      wr_q    <= wr_nx;
      split_q <= split_nx;
      nar_q   <= narrow_nx;
    end
  end

  // R8: a low ready with the wait count used up keeps the strobe phase
  a_r8_rdy_stretch: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STRB && cnt_q == '0 && !rdy_n) |=> (st_q == ST_STRB));

  // R7: remaining wait clocks keep the strobe phase regardless of ready
  a_r7_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STRB && cnt_q != '0) |=> (st_q == ST_STRB));

  // R11: hold is entered only from idle
  a_r11_hold_entry: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) |-> ($past(st_q) == ST_IDLE || $past(st_q) == ST_HOLD));
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
#(
  parameter int AW   = 24,
  parameter int NREG = 4,
  parameter int WW   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [AW-1:0]      addr,
  input  logic               acc_word,
  input  logic               acc_write,
  input  logic               narrow_bus,
  input  logic               split_strobes,
  input  logic [NREG*WW-1:0] wait_cfg,
  input  logic               rdy_n,
  input  logic               hold_n,
  output logic [AW-1:0]      ext_addr,
  output logic               rd_n,
  output logic               wr_lo_n,
  output logic               wr_hi_n,
  output logic               addr_latch,
  output logic               hold_ack_n,
  output logic               acc_done
);
  xb_state_e     st_nx;
  logic [AW-1:0] addr_nx;
  logic          word_nx, wr_nx, split_nx, narrow_nx;
  logic          d_rd_n, d_lo_n, d_hi_n, d_ale;

  xbus_seq #(.AW(AW), .NREG(NREG), .WW(WW)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .req           (req),
    .addr          (addr),
    .acc_word      (acc_word),
    .acc_write     (acc_write),
    .narrow_bus    (narrow_bus),
    .split_strobes (split_strobes),
    .wait_cfg      (wait_cfg),
    .rdy_n         (rdy_n),
    .hold_n        (hold_n),
    .st_nx         (st_nx),
    .addr_nx       (addr_nx),
    .word_nx       (word_nx),
    .wr_nx         (wr_nx),
    .split_nx      (split_nx),
    .narrow_nx     (narrow_nx)
  );

  xbus_strobe_dec u_dec (
    .st     (st_nx),
    .is_wr  (wr_nx),
    .split  (split_nx),
    .narrow (narrow_nx),
    .word   (word_nx),
    .odd    (addr_nx[0]),
    .rd_n   (d_rd_n),
    .lo_n   (d_lo_n),
    .hi_n   (d_hi_n),
    .ale    (d_ale)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_addr   <= {1'b1, {(AW-1){1'b0}}};
      rd_n       <= 1'b1;
      wr_lo_n    <= 1'b1;
      wr_hi_n    <= 1'b1;
      addr_latch <= 1'b0;
      hold_ack_n <= 1'b1;
      acc_done   <= 1'b0;
    end else begin
      ext_addr   <= {~addr_nx[AW-1], addr_nx[AW-2:0]};
      rd_n       <= d_rd_n;
      wr_lo_n    <= d_lo_n;
      wr_hi_n    <= d_hi_n;
      addr_latch <= d_ale;
      hold_ack_n <= !(st_nx == ST_HOLD);
      acc_done   <= (st_nx == ST_END);
    end
  end

  // R2: the latch clock carries no strobe
  a_r2_ale_quiet: assert property (@(posedge clk) disable iff (rst)
    addr_latch |-> (rd_n && wr_lo_n && wr_hi_n));

  // R2: the strobe phase follows the latch clock directly
  a_r2_ale_then_strobe: assert property (@(posedge clk) disable iff (rst)
    addr_latch |=> (!rd_n || !wr_lo_n || !wr_hi_n));

  // R3: read and write strobes never overlap
  a_r3_no_rd_wr: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_lo_n));

  // R9: completion is a single-clock pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    acc_done |=> !acc_done);

  // R10: nothing is driven onto the bus while held
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    !hold_ack_n |-> (!addr_latch && rd_n && wr_lo_n && wr_hi_n));

  // R12: hold acknowledge drops one edge after hold is withdrawn
  a_r12_release: assert property (@(posedge clk) disable iff (rst)
    (!hold_ack_n && hold_n) |=> hold_ack_n);
endmodule

// File: tb/test_xbus_strobe_gen.sv
module test_xbus_strobe_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic        acc_word = 1'b0, acc_write = 1'b0;
  logic        narrow_bus = 1'b0, split_strobes = 1'b1;
  logic [7:0]  wait_cfg = 8'hE4;
  logic        rdy_n = 1'b1, hold_n = 1'b1;
  logic [23:0] ext_addr;
  logic        rd_n, wr_lo_n, wr_hi_n, addr_latch, hold_ack_n, acc_done;

  int nchk = 0;
  int nfail = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  xbus_strobe_gen i_xbus_strobe_gen (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .acc_word(acc_word),
    .acc_write(acc_write), .narrow_bus(narrow_bus), .split_strobes(split_strobes),
    .wait_cfg(wait_cfg), .rdy_n(rdy_n), .hold_n(hold_n), .ext_addr(ext_addr),
    .rd_n(rd_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .addr_latch(addr_latch),
    .hold_ack_n(hold_ack_n), .acc_done(acc_done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  function automatic logic [2:0] exp_pat(input logic sp, nb, w, wd, od);
    logic l, h;
    if (sp) begin
      l = !(w && (nb || wd || !od));
      h = !(w && !nb && (wd || od));
    end else begin
      l = !w;
      h = !(wd || od);
    end
    return {w, l, h};
  endfunction

  function automatic int wait_of(input logic [23:0] a);
    return int'(wait_cfg[2*a[23:22] +: 2]);
  endfunction

  task automatic run_txn(input logic [23:0] a, input logic s16, input logic w, input int rdy_k);
    int k, tdone, ncyc, exp_done;
    int len [2];
    int bad [2];
    logic [2:0]  badv [2];
    logic [23:0] seen [2];
    logic [23:0] ak;
    logic [2:0]  ep;
    string ptag;
    k = -1; tdone = 0;
    len = '{0, 0}; bad = '{0, 0}; badv = '{3'b0, 3'b0}; seen = '{24'h0, 24'h0};
    ncyc = (s16 && (narrow_bus || a[0])) ? 2 : 1;
    addr = a; acc_word = s16; acc_write = w;
    if (rdy_k > 0) rdy_n = 1'b0;
    req = 1'b1;
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (addr_latch) begin
        k++;
        if (k < 2) seen[k] = ext_addr;
      end else if (!rd_n || !wr_lo_n || !wr_hi_n) begin
        if (k >= 0 && k < 2) begin
          len[k]++;
          ak = a + 24'(k);
          ep = exp_pat(split_strobes, narrow_bus, w, s16 && ncyc == 1, ak[0]);
          if ({rd_n, wr_lo_n, wr_hi_n} != ep) begin
            bad[k]++;
            badv[k] = {rd_n, wr_lo_n, wr_hi_n};
          end
          if (rdy_k > 0 && len[k] >= rdy_k) rdy_n = 1'b1;
        end
      end
      if (acc_done) begin
        tdone = i;
        chk(rd_n && wr_lo_n && wr_hi_n, "R9", "strobes at done",
            {rd_n, wr_lo_n, wr_hi_n}, 3'b111);
        break;
      end
    end
    req = 1'b0;
    rdy_n = 1'b1;
    chk(k + 1 == ncyc, "R6", "bus cycle count", k + 1, ncyc);
    exp_done = 1;
    for (int c = 0; c < ncyc && c < 2; c++) begin
      int el;
      ak = a + 24'(c);
      el = wait_of(ak) + 1;
      if (rdy_k > el) el = rdy_k;
      exp_done += 1 + el;
      chk(seen[c] == {~ak[23], ak[22:0]}, "R2", "latched address", seen[c], {~ak[23], ak[22:0]});
      chk(len[c] == el, (rdy_k > 0) ? "R8" : "R7", "strobe length", len[c], el);
      ptag = w ? (split_strobes ? "R4" : "R5") : (split_strobes ? "R3" : "R5");
      ep = exp_pat(split_strobes, narrow_bus, w, s16 && ncyc == 1, ak[0]);
      chk(bad[c] == 0, ptag, "strobe pattern", badv[c], ep);
    end
    chk(tdone == exp_done, "R9", "done clock", tdone, exp_done);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk({rd_n, wr_lo_n, wr_hi_n, hold_ack_n} == 4'hF && !addr_latch && !acc_done,
        "R1", "reset outputs", {rd_n, wr_lo_n, wr_hi_n, hold_ack_n, addr_latch, acc_done}, 6'b111100);
    rst = 1'b0;
    @(negedge clk);
    chk({rd_n, wr_lo_n, wr_hi_n, hold_ack_n} == 4'hF && !addr_latch && !acc_done,
        "R1", "first idle outputs", {rd_n, wr_lo_n, wr_hi_n, hold_ack_n, addr_latch, acc_done}, 6'b111100);

    // Main sweep: R2..R7, R9
    for (int sp = 0; sp < 2; sp++)
      for (int nb = 0; nb < 2; nb++)
        for (int cf = 0; cf < 2; cf++)
          for (int rg = 0; rg < 4; rg++)
            for (int s = 0; s < 2; s++)
              for (int w = 0; w < 2; w++)
                for (int o = 0; o < 2; o++) begin
                  split_strobes = sp[0];
                  narrow_bus = nb[0];
                  wait_cfg = cf[0] ? 8'h1B : 8'hE4;
                  run_txn({rg[1:0], 21'h0B3C5A, o[0]}, s[0], w[0], 0);
                end

    // R6/R7: word split across a region boundary and across the address wrap
    split_strobes = 1'b1; narrow_bus = 1'b0; wait_cfg = 8'hE4;
    run_txn(24'h3FFFFF, 1'b1, 1'b1, 0);
    run_txn(24'hFFFFFF, 1'b1, 1'b0, 0);
    split_strobes = 1'b0; narrow_bus = 1'b1;
    run_txn(24'hBFFFFF, 1'b1, 1'b1, 0);

    // R8: ready held low beyond and within the wait count
    split_strobes = 1'b1; narrow_bus = 1'b0; wait_cfg = 8'hE4;
    run_txn(24'h412340, 1'b0, 1'b0, 5);
    run_txn(24'hC12340, 1'b0, 1'b1, 2);
    run_txn(24'h012341, 1'b0, 1'b1, 4);

    // R10/R12: hold and request raised together while idle
    addr = 24'h000010; acc_word = 1'b0; acc_write = 1'b0;
    hold_n = 1'b0; req = 1'b1;
    @(negedge clk);
    chk(!hold_ack_n && !addr_latch, "R10", "hold wins over request",
        {hold_ack_n, addr_latch}, 2'b00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!hold_ack_n && !addr_latch && rd_n && wr_lo_n && wr_hi_n, "R10", "bus quiet in hold",
          {hold_ack_n, addr_latch, rd_n, wr_lo_n, wr_hi_n}, 5'b00111);
    end
    hold_n = 1'b1;
    @(negedge clk);
    chk(hold_ack_n && !addr_latch, "R12", "hold released", {hold_ack_n, addr_latch}, 2'b10);
    @(negedge clk);
    chk(addr_latch == 1'b1, "R12", "request starts after release", addr_latch, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (acc_done) break;
    end
    req = 1'b0;
    @(negedge clk);

    // R11: hold raised during an access waits for completion
    begin
      bit held_early;
      held_early = 0;
      addr = 24'hC00020; acc_word = 1'b0; acc_write = 1'b1; req = 1'b1;
      @(negedge clk);
      chk(addr_latch == 1'b1, "R9", "latch one clock after request", addr_latch, 1);
      hold_n = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!hold_ack_n) held_early = 1;
        if (acc_done) break;
      end
      req = 1'b0;
      chk(!held_early, "R11", "no grant inside access", held_early, 0);
      chk(acc_done == 1'b1, "R11", "access completed under hold", acc_done, 1);
      @(negedge clk);
      chk(hold_ack_n == 1'b1, "R11", "idle clock before grant", hold_ack_n, 1);
      @(negedge clk);
      chk(hold_ack_n == 1'b0, "R11", "grant after completion", hold_ack_n, 0);
      hold_n = 1'b1;
      @(negedge clk);
      chk(hold_ack_n == 1'b1, "R12", "release after mid-access hold", hold_ack_n, 1);
    end

    report();
  end
endmodule